// File: doc/BRIEF.md
# Compare-Triggered Sync Pulse Generator

The block watches a free-running 64-bit time count supplied by a neighbouring counter and compares it against a bank of programmable compare values. When the count reaches or steps over an enabled compare value, the matching status bit latches. Status stays set until software clears it. The status bit of compare 1 drives an interrupt line. The same compare-1 event starts a pulse sequencer that drives two sync outputs.

The sequencer waits a programmed number of clock ticks, then holds its output high for a programmed number of ticks. With a zero period it runs once per event. With a nonzero period it keeps repeating until software turns it off. Compare 0 can be set to request a count reset, so the time base wraps at a fixed cycle length. In shadow mode, new compare values wait for that wrap before they take effect.

Registers sit behind a 32-bit write port and a combinational read port. Word addresses: 0 compare configuration, 1 compare status, 2 sync control, 3 pulse width, 4 start delay, 5 repeat period. Compare n has its low word at 8+2n and its high word at 9+2n.

Top module: `cmp_sync_gen`

## Requirements
- R1: An enabled compare n sets status bit n at the clock edge where the sampled count is at or above the compare value and the previous sample was below it (or the count has just wrapped below the previous sample). A step of several units therefore cannot jump over the value, and the bit is not set again while the count stays above.
- R2: Configuration bit n+1 enables compare n. A disabled compare never sets its status bit.
- R3: Status bits are sticky. Writing 1 to status bit n at address 1 clears it. A match in the same cycle wins over the clear.
- R4: `irq_o` is high exactly while status bit 1 is set.
- R5: When configuration bit 0 is set, a compare-0 match gives a one-cycle `cnt_clr_o` pulse in the cycle after the matching edge.
- R6: When configuration bit NCMP+1 (bit 17 by default) is set, compare writes land in a holding copy. The holding copy moves to the active compare at the next compare-0 match. Reads return the active value.
- R7: A compare-1 match while sync control bit 0 is set starts the sequencer. The sync output rises at the (D+1)-th clock edge after the matching edge, where D is the start delay.
- R8: The pulse stays high for W clock cycles, where W is the width register. A width of 0 gives no pulse.
- R9: With period 0, one pulse is produced per event. With period P nonzero, a new pulse starts every P cycles until sync is disabled.
- R10: Sync control bit 1 gates `sync0_o` and bit 2 gates `sync1_o`. Writing 0 to sync control forces both outputs low from the cycle after the write and stops the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write word address |
| wr_data | input | DW | Register write data |
| rd_addr | input | AW | Register read word address |
| rd_data | output | DW | Register read data (combinational) |
| cnt_i | input | 2*DW | Current time count |
| cnt_clr_o | output | 1 | Request to reset the time count |
| irq_o | output | 1 | Compare-1 interrupt |
| sync0_o | output | 1 | Sync output 0 |
| sync1_o | output | 1 | Sync output 1 |

## Verification
A wrong previous-sample register or a wrong compare operand shows up as a status bit that sets one count step early, late or twice. It becomes visible on the status read the cycle after the crossing edge. Sequencer counter faults appear on the sync pins as a rise edge displaced from D+1 cycles, a pulse width other than W, or repeat spacing other than P, all within one pulse period. A broken shadow transfer leaves the read-back compare value unchanged after a count wrap. A broken counter-reset path stretches the wrap interval at `cnt_clr_o` beyond the compare-0 value divided by the step, plus one.

// File: rtl/cmp_sync_gen.sv
module cmp_sync_gen #(
  parameter int NCMP = 16,
  parameter int DW   = 32,
  parameter int AW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  input  logic [2*DW-1:0] cnt_i,
  output logic            cnt_clr_o,
  output logic            irq_o,
  output logic            sync0_o,
  output logic            sync1_o
);
  localparam int CW    = 2 * DW;
  localparam int SHB   = NCMP + 1;
  localparam int A_CFG = 0;
  localparam int A_STS = 1;
  localparam int A_CTL = 2;
  localparam int A_WID = 3;
  localparam int A_DLY = 4;
  localparam int A_PER = 5;
  localparam int A_CMP = 8;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_HIGH, S_LOW} st_t;

  logic [NCMP+1:0] cfg;
  logic [NCMP-1:0] sts, hit, sts_clr;
  logic [2:0]      ctl;
  logic [DW-1:0]   wid, dly, per, t, pc;
  logic [CW-1:0]   prev;
  logic [CW-1:0]   act_a [NCMP];
  st_t             st;

  wire wr_cfg = wr_en && wr_addr == AW'(A_CFG);
  wire wr_sts = wr_en && wr_addr == AW'(A_STS);
  wire wr_ctl = wr_en && wr_addr == AW'(A_CTL);
  wire shadow = cfg[SHB];
  wire load   = shadow && hit[0];
  wire go     = hit[1] && ctl[0];

  assign sts_clr = wr_sts ? wr_data[NCMP-1:0] : '0;

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    logic [CW-1:0] sh_r, act_r;
    wire wlo = wr_en && wr_addr == AW'(A_CMP + 2 * g);
    wire whi = wr_en && wr_addr == AW'(A_CMP + 2 * g + 1);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_r  <= '0;
        act_r <= '0;
      end else begin
        if (wlo) sh_r[DW-1:0] <= wr_data;
        if (whi) sh_r[CW-1:DW] <= wr_data;
        if (!shadow) begin
          if (wlo) act_r[DW-1:0] <= wr_data;
          if (whi) act_r[CW-1:DW] <= wr_data;
        end else if (load) begin
          act_r <= sh_r;
        end
      end
    end
    assign act_a[g] = act_r;
    assign hit[g]   = cfg[g+1] && (cnt_i >= act_r) && ((prev < act_r) || (cnt_i < prev));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0; sts <= '0; ctl <= '0;
      wid <= '0; dly <= '0; per <= '0;
      prev <= '0; cnt_clr_o <= 1'b0;
    end else begin
      if (wr_cfg) cfg <= wr_data[NCMP+1:0];
      if (wr_ctl) ctl <= wr_data[2:0];
      if (wr_en && wr_addr == AW'(A_WID)) wid <= wr_data;
      if (wr_en && wr_addr == AW'(A_DLY)) dly <= wr_data;
      if (wr_en && wr_addr == AW'(A_PER)) per <= wr_data;
      sts       <= (sts & ~sts_clr) | hit;
      prev      <= cnt_i;
      cnt_clr_o <= hit[0] && cfg[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; t <= '0; pc <= '0;
    end else if (!ctl[0]) begin
      st <= S_IDLE;
    end else if (go) begin
      st <= S_WAIT;
      t  <= dly;
    end else begin
      case (st)
        S_WAIT:
          if (t != '0) t <= t - 1'b1;
          else if (wid == '0) st <= S_IDLE;
          else begin
            st <= S_HIGH; t <= wid - 1'b1; pc <= per - 1'b1;
          end
        S_HIGH:
          if (per != '0 && pc == '0) begin
            t <= wid - 1'b1; pc <= per - 1'b1;
          end else begin
            pc <= pc - 1'b1;
            if (t == '0) st <= (per == '0) ? S_IDLE : S_LOW;
            else t <= t - 1'b1;
          end
        S_LOW:
          if (pc == '0) begin
            st <= S_HIGH; t <= wid - 1'b1; pc <= per - 1'b1;
          end else pc <= pc - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign irq_o   = sts[1];
  assign sync0_o = st == S_HIGH && ctl[0] && ctl[1];
  assign sync1_o = st == S_HIGH && ctl[0] && ctl[2];

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      AW'(A_CFG): rd_data = DW'(cfg);
      AW'(A_STS): rd_data = DW'(sts);
      AW'(A_CTL): rd_data = DW'(ctl);
      AW'(A_WID): rd_data = wid;
      AW'(A_DLY): rd_data = dly;
      AW'(A_PER): rd_data = per;
      default: ;
    endcase
    for (int n = 0; n < NCMP; n++) begin
      if (rd_addr == AW'(A_CMP + 2 * n))     rd_data = act_a[n][DW-1:0];
      if (rd_addr == AW'(A_CMP + 2 * n + 1)) rd_data = act_a[n][CW-1:DW];
    end
  end

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[1] && !(wr_sts && wr_data[1])) |=> sts[1]);

  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg[2] && !sts[1]) |=> !sts[1]);

  p_clr_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr_o |-> $past(cfg[0]));

  p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !wr_data[0]) |=> (!sync0_o && !sync1_o));

  p_irq_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && wr_data[1] && !hit[1]) |=> !irq_o);
endmodule

// File: tb/sim_cmp_sync_gen.sv
module sim_cmp_sync_gen;
  localparam int DW = 32, AW = 6, INC = 4;
  localparam int A_CFG = 0, A_STS = 1, A_CTL = 2, A_WID = 3, A_DLY = 4, A_PER = 5;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic [63:0] cnt = '0;
  logic run = 0;
  logic cnt_clr_o, irq_o, sync0_o, sync1_o;
  int errors = 0, checks = 0;

  cmp_sync_gen #(.NCMP(16), .DW(DW), .AW(AW)) u0 (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .cnt_i(cnt), .cnt_clr_o, .irq_o, .sync0_o, .sync1_o);

  always #5 clk = ~clk;

  always @(negedge clk)
    if (cnt_clr_o) cnt <= '0;
    else if (run) cnt <= cnt + INC;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    rd_addr = AW'(a); #1; d = rd_data;
  endtask

  task automatic trigger();
    wr(A_STS, '1);
    wr(10, DW'(cnt + 400));
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 1000 && !irq_o; i++) @(negedge clk);
  endtask

  task automatic pulse(input int d, input int w);
    int k, n;
    wr(A_DLY, d); wr(A_WID, w);
    trigger(); wait_irq();
    k = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); k++;
      if (sync0_o) break;
    end
    chk("R7 start delay", k, d + 1);
    n = 0;
    while (sync0_o && n < 200) begin n++; @(negedge clk); end
    chk("R8 pulse width", n, w);
  endtask

  initial begin
    logic [DW-1:0] v;
    int k, hi0, hi1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(A_STS, v);
    chk("reset status", v, 0);
    chk("reset irq", irq_o, 0);
    chk("reset sync", {sync0_o, sync1_o}, 0);

    // R1: crossing sweep over offsets with step 4, compare 2
    wr(A_CFG, 32'h8);
    for (int off = 0; off < 8; off++) begin
      @(negedge clk); cnt = 990;
      @(negedge clk);
      wr(A_STS, '1);
      wr(12, 1000 + off);
      for (int s = 0; s < 8; s++) begin
        @(negedge clk); cnt = cnt + INC;
        @(negedge clk); rd(A_STS, v);
        chk("R1 crossing", v[2], cnt >= 64'(1000 + off));
      end
    end
    // R3 write-1-to-clear
    wr(A_STS, 32'h4);
    rd(A_STS, v);
    chk("R3 clear", v[2], 0);

    // R2 disabled compare 3
    run = 1;
    wr(14, DW'(cnt + 40));
    repeat (60) @(negedge clk);
    rd(A_STS, v);
    chk("R2 disabled", v[3], 0);

    // R7/R8 one-shot sweep on sync0
    wr(A_CFG, 32'h4);
    wr(A_PER, 0);
    wr(A_CTL, 3'b011);
    for (int d = 0; d < 3; d++)
      for (int w = 1; w < 4; w++)
        pulse(d * 2, w * 2 - 1);

    // R9 one-shot: no second pulse; R4 irq held
    hi0 = 0;
    repeat (80) begin @(negedge clk); if (sync0_o) hi0++; end
    chk("R9 one-shot", hi0, 0);
    chk("R4 irq held", irq_o, 1);
    wr(A_STS, 32'h2);
    chk("R4 irq cleared", irq_o, 0);

    // R8 width zero
    wr(A_WID, 0); wr(A_DLY, 1);
    trigger(); wait_irq();
    hi0 = 0;
    repeat (40) begin @(negedge clk); if (sync0_o) hi0++; end
    chk("R8 zero width", hi0, 0);

    // R9 periodic
    wr(A_WID, 3); wr(A_DLY, 2); wr(A_PER, 10);
    trigger(); wait_irq();
    for (int i = 0; i < 200 && !sync0_o; i++) @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      k = 0;
      while (sync0_o && k < 100) begin @(negedge clk); k++; end
      while (!sync0_o && k < 100) begin @(negedge clk); k++; end
      chk("R9 period", k, 10);
    end
    // R10 stop
    wr(A_CTL, 0);
    chk("R10 stop", {sync0_o, sync1_o}, 0);
    hi0 = 0;
    repeat (30) begin @(negedge clk); if (sync0_o || sync1_o) hi0++; end
    chk("R10 stays stopped", hi0, 0);

    // R10 gating: only sync1
    wr(A_PER, 0); wr(A_WID, 4); wr(A_DLY, 0);
    wr(A_CTL, 3'b101);
    trigger(); wait_irq();
    hi0 = 0; hi1 = 0;
    repeat (30) begin @(negedge clk); hi0 += int'(sync0_o); hi1 += int'(sync1_o); end
    chk("R10 sync0 gated", hi0, 0);
    chk("R10 sync1 width", hi1, 4);

    // R5 counter reset
    run = 0;
    @(negedge clk); cnt = 0;
    wr(A_CFG, 32'h3 | 32'h8);
    wr(8, 200); wr(9, 0);
    wr(12, 100);
    run = 1;
    for (int i = 0; i < 500 && !cnt_clr_o; i++) @(negedge clk);
    k = 0;
    @(negedge clk); k++;
    chk("R5 single-cycle", cnt_clr_o, 0);
    while (!cnt_clr_o && k < 500) begin @(negedge clk); k++; end
    chk("R5 wrap interval", k, 200 / INC + 1);

    // R6 shadow
    wr(A_CFG, (32'h1 << 17) | 32'h3 | 32'h8);
    wr(12, 150);
    rd(12, v);
    chk("R6 held", v, 100);
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < 500 && !cnt_clr_o; i++) @(negedge clk);
      @(negedge clk);
    end
    rd(12, v);
    chk("R6 transferred", v, 150);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule